// File: doc/BRIEF.md
# Receiver Idle Time-out Counter

This block watches a serial receiver for silence once traffic has begun. Software gives it an 8-bit time-out value and a start strobe. From then on it stays quiet until the receiver reports a first character. That character loads a down counter with the time-out value. Each later character reloads the counter. The counter steps down once every four bit-period ticks. When it reaches zero, a sticky status flag is raised.

The full idle window is therefore the time-out value times four bit periods, measured from the most recent character. A time-out value of zero turns detection off. After the flag fires, the block ignores further characters until software strobes start again. The strobe also clears the flag. The receiver itself, the bit clock and any interrupt routing sit outside this block.

Top module: `rx_idle_timeout`

## Requirements
- R1: While `timeout_val` is 0, a character does not arm the counter. If the value becomes 0 while counting, counting stops and the block waits for a new first character. In neither case is the flag raised.
- R2: After reset or a start strobe, bit ticks have no effect and the flag stays low until a character arrives with a nonzero `timeout_val`.
- R3: The first character after arming loads the value N. The flag rises on the clock edge that takes the 4N-th bit tick after that character, and not earlier.
- R4: Every character received while counting reloads N and restarts the divide-by-four phase. The window is then measured from the latest character.
- R5: The flag is set exactly when the count steps from one to zero.
- R6: `start_req` clears the flag and returns the block to waiting for a first character. A character in the same cycle as the strobe is ignored.
- R7: The count advances only on cycles where `bit_tick` is high. Cycles without a tick change nothing, however many of them there are.
- R8: Once set, the flag stays high, and later characters and ticks do not restart counting until `start_req`.
- R9: When a character and a bit tick arrive in the same cycle, the reload wins and that tick is not counted.
- R10: Reset leaves the flag low and the block waiting for a first character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timeout_val | input | 8 | Programmed time-out in units of four bit periods; 0 disables |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| char_rx | input | 1 | One-cycle pulse per received character |
| start_req | input | 1 | Software strobe that clears the flag and re-arms |
| timeout_flag | output | 1 | Sticky idle time-out status |

## Verification
The only window onto the counter is the edge on which the flag rises. A wrong load value, a missed reload, or a divide phase that is not cleared therefore shows up as the flag rising a few ticks early or late. Small values of N, counted tick by tick, expose this within one time-out window. A stuck state, such as counting while it should wait or continuing after expiry, shows as a flag that appears with no character or never appears at all. The dormant, zero-value and sticky scenarios catch these within tens of ticks.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } rxto_state_e;

  // bit ticks needed for a programmed value
  function automatic int unsigned ticks_for_value(input int unsigned val,
                                                  input int unsigned div);
    return val * div;
  endfunction

  // true when the prescaler phase is the last one before a unit step
  function automatic logic is_last_phase(input int unsigned ph,
                                         input int unsigned div);
    return ph == (div - 1);
  endfunction

  function automatic logic is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/rxto_prescaler.sv
module rxto_prescaler #(
  parameter int unsigned DIV = 4,
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          bit_tick,
  output logic [PW-1:0] phase,
  output logic          unit_tick
);
  import rxto_pkg::*;

  logic [PW-1:0] ph_q, ph_nxt;
  logic          last;

  assign last      = is_last_phase(int'(ph_q), DIV);
  assign unit_tick = en && bit_tick && last;
  assign phase     = ph_q;

  generate
    if (is_pow2(DIV) && (DIV > 1)) begin : g_wrap
      assign ph_nxt = ph_q + PW'(1);
    end else begin : g_cmp
      assign ph_nxt = last ? '0 : ph_q + PW'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ph_q <= '0;
    else if (clr)             ph_q <= '0;
    else if (en && bit_tick)  ph_q <= ph_nxt;
  end
endmodule

// File: rtl/rxto_downcount.sv
module rxto_downcount #(
  parameter int unsigned VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VAL_W-1:0] load_val,
  input  logic             clr,
  input  logic             dec,
  output logic [VAL_W-1:0] cnt,
  output logic             hit_zero
);
  logic [VAL_W-1:0] cnt_q;

  assign cnt      = cnt_q;
  assign hit_zero = dec && (cnt_q == VAL_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (clr)                   cnt_q <= '0;
    else if (dec && cnt_q != '0)    cnt_q <= cnt_q - VAL_W'(1);
  end
endmodule

// File: rtl/rxto_ctrl.sv
module rxto_ctrl
  import rxto_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_req,
  input  logic        char_rx,
  input  logic        val_zero,
  input  logic        hit_zero,
  output rxto_state_e state,
  output logic        load,
  output logic        clr,
  output logic        run,
  output logic        flag
);
  rxto_state_e st_q, st_nxt;
  logic        flag_q, flag_nxt;

  always_comb begin
    st_nxt   = st_q;
    flag_nxt = flag_q;
    load     = 1'b0;
    clr      = 1'b0;
    if (start_req) begin
      st_nxt   = ST_WAIT;
      flag_nxt = 1'b0;
      clr      = 1'b1;
    end else begin
      unique case (st_q)
        ST_WAIT: begin
          if (char_rx && !val_zero) begin
            load   = 1'b1;
            st_nxt = ST_RUN;
          end else begin
            clr = 1'b1;
          end
        end
        ST_RUN: begin
          if (val_zero) begin
            clr    = 1'b1;
            st_nxt = ST_WAIT;
          end else if (char_rx) begin
            load = 1'b1;
          end else if (hit_zero) begin
            st_nxt   = ST_DONE;
            flag_nxt = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign run   = (st_q == ST_RUN) && !start_req && !val_zero && !char_rx;
  assign state = st_q;
  assign flag  = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_WAIT;
      flag_q <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      flag_q <= flag_nxt;
    end
  end
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout #(
  parameter int unsigned VAL_W = 8,
  parameter int unsigned DIV   = 4,
  localparam int unsigned PW   = (DIV > 2) ? $clog2(DIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] timeout_val,
  input  logic             bit_tick,
  input  logic             char_rx,
  input  logic             start_req,
  output logic             timeout_flag
);
  import rxto_pkg::*;

  rxto_state_e      st_q;
  logic             load_ev, clr_ev, run_en, unit_tick, hit_zero;
  logic             val_zero;
  logic [VAL_W-1:0] cnt_q;
  logic [PW-1:0]    pre_q;

  assign val_zero = (timeout_val == '0);

  rxto_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_req(start_req),
    .char_rx  (char_rx),
    .val_zero (val_zero),
    .hit_zero (hit_zero),
    .state    (st_q),
    .load     (load_ev),
    .clr      (clr_ev),
    .run      (run_en),
    .flag     (timeout_flag)
  );

  rxto_prescaler #(.DIV(DIV)) pre_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (load_ev || clr_ev),
    .en       (run_en),
    .bit_tick (bit_tick),
    .phase    (pre_q),
    .unit_tick(unit_tick)
  );

  rxto_downcount #(.VAL_W(VAL_W)) cnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_ev),
    .load_val(timeout_val),
    .clr     (clr_ev),
    .dec     (unit_tick),
    .cnt     (cnt_q),
    .hit_zero(hit_zero)
  );
endmodule

// File: rtl/rx_idle_timeout_chk.sv
module rx_idle_timeout_chk
  import rxto_pkg::*;
#(
  parameter int unsigned VAL_W = 8,
  parameter int unsigned PW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VAL_W-1:0] timeout_val,
  input logic             bit_tick,
  input logic             char_rx,
  input logic             start_req,
  input logic             timeout_flag,
  input rxto_state_e      st_q,
  input logic [VAL_W-1:0] cnt_q,
  input logic [PW-1:0]    pre_q,
  input logic             unit_tick
);
  a_r1_zero_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_val == '0 && !timeout_flag) |=> !timeout_flag);

  a_r2_wait_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !char_rx) |=> !timeout_flag && st_q != ST_RUN || start_req);

  a_r3_first_load: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && char_rx && timeout_val != '0 && !start_req)
      |=> cnt_q == $past(timeout_val) && st_q == ST_RUN);

  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && char_rx && timeout_val != '0 && !start_req)
      |=> cnt_q == $past(timeout_val) && pre_q == '0);

  a_r5_fire_at_one: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> $past(cnt_q) == VAL_W'(1) && $past(unit_tick));

  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !timeout_flag && st_q == ST_WAIT);

  a_r7_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !bit_tick && !char_rx && !start_req && timeout_val != '0)
      |=> $stable(cnt_q) && $stable(pre_q));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !start_req) |=> timeout_flag);

  a_r9_no_unit_on_char: assert property (@(posedge clk) disable iff (!rst_n)
    char_rx |-> !unit_tick);
endmodule

bind rx_idle_timeout rx_idle_timeout_chk #(.VAL_W(VAL_W), .PW(PW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .timeout_val (timeout_val),
  .bit_tick    (bit_tick),
  .char_rx     (char_rx),
  .start_req   (start_req),
  .timeout_flag(timeout_flag),
  .st_q        (st_q),
  .cnt_q       (cnt_q),
  .pre_q       (pre_q),
  .unit_tick   (unit_tick)
);

// File: tb/rx_idle_timeout_tb.sv
module rx_idle_timeout_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] timeout_val = '0;
  logic       bit_tick = 1'b0;
  logic       char_rx = 1'b0;
  logic       start_req = 1'b0;
  logic       timeout_flag;
  int         n_checks = 0;
  int         n_errors = 0;

  always #2 clk = ~clk;

  rx_idle_timeout dut_i (
    .clk(clk), .rst_n(rst_n), .timeout_val(timeout_val), .bit_tick(bit_tick),
    .char_rx(char_rx), .start_req(start_req), .timeout_flag(timeout_flag)
  );

  // window in ticks restated from the requirement: value times four
  function automatic int window(input int v);
    int t = 0;
    for (int k = 0; k < v; k++) t += 4;
    return t;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: timeout_flag=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_char();
    @(negedge clk) char_rx = 1'b1;
    @(negedge clk) char_rx = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic t_reset();
    idle(2);
    check(timeout_flag, 1'b0, "R10 reset");
    ticks(30);
    check(timeout_flag, 1'b0, "R10 waits after reset");
  endtask

  task automatic t_dormant();
    timeout_val = 8'd1;
    pulse_start();
    ticks(50);
    check(timeout_flag, 1'b0, "R2 no count before first char");
  endtask

  task automatic t_basic(input int v);
    timeout_val = 8'(v);
    pulse_start();
    pulse_char();
    ticks(window(v) - 1);
    check(timeout_flag, 1'b0, "R3 not before 4N ticks");
    ticks(1);
    check(timeout_flag, 1'b1, "R3 R5 flag at 4N ticks");
  endtask

  task automatic t_reload();
    timeout_val = 8'd2;
    pulse_start();
    pulse_char();
    ticks(6);
    pulse_char();
    ticks(7);
    check(timeout_flag, 1'b0, "R4 reload restarts window");
    ticks(1);
    check(timeout_flag, 1'b1, "R4 flag 4N after latest char");
  endtask

  task automatic t_gaps();
    timeout_val = 8'd1;
    pulse_start();
    pulse_char();
    ticks(1); idle(13); ticks(2); idle(21);
    check(timeout_flag, 1'b0, "R7 idle cycles do not count");
    ticks(1);
    check(timeout_flag, 1'b1, "R7 fourth tick fires");
  endtask

  task automatic t_sticky();
    // flag is high from previous scenario
    pulse_char(); ticks(20); pulse_char(); idle(5);
    check(timeout_flag, 1'b1, "R8 flag sticky after chars");
    pulse_start();
    check(timeout_flag, 1'b0, "R6 start clears flag");
  endtask

  task automatic t_zero();
    timeout_val = 8'd0;
    pulse_start();
    pulse_char();
    ticks(40);
    check(timeout_flag, 1'b0, "R1 zero value never arms");
    timeout_val = 8'd2;
    pulse_char();
    ticks(3);
    @(negedge clk) timeout_val = 8'd0;
    ticks(20);
    @(negedge clk) timeout_val = 8'd2;
    ticks(20);
    check(timeout_flag, 1'b0, "R1 zero while counting stops it");
  endtask

  task automatic t_start_prio();
    timeout_val = 8'd1;
    pulse_start(); pulse_char(); ticks(4);
    check(timeout_flag, 1'b1, "R6 setup flag high");
    @(negedge clk) begin start_req = 1'b1; char_rx = 1'b1; end
    @(negedge clk) begin start_req = 1'b0; char_rx = 1'b0; end
    check(timeout_flag, 1'b0, "R6 start clears flag");
    ticks(12);
    check(timeout_flag, 1'b0, "R6 char with start ignored");
  endtask

  task automatic t_same_cycle();
    timeout_val = 8'd1;
    pulse_start(); pulse_char(); ticks(3);
    @(negedge clk) begin char_rx = 1'b1; bit_tick = 1'b1; end
    @(negedge clk) begin char_rx = 1'b0; bit_tick = 1'b0; end
    ticks(3);
    check(timeout_flag, 1'b0, "R9 tick with char not counted");
    ticks(1);
    check(timeout_flag, 1'b1, "R9 fires after full window");
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_dormant();
    t_basic(3);
    t_basic(1);
    t_reload();
    t_gaps();
    t_sticky();
    t_zero();
    t_start_prio();
    t_same_cycle();
    t_basic(255);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule